// File: doc/BRIEF.md
# Dual Compare Pulse Output Channel

This block is one output channel of a timer. A free-running counter elsewhere on the chip drives a shared count bus and pulses an update strobe whenever the bus takes a new value. The channel holds two compare values: a leading-edge value and a trailing-edge value. When the updated count equals the leading value, an internal output flip-flop is set. When it equals the trailing value, the flip-flop is cleared. The pin therefore shows a pulse whose edges are placed by software.

In continuous mode the channel produces a pulse every time the counter passes the two values. A match flag records these events. In one-shot mode the channel emits a single pulse and then disarms both comparators. A new write to either compare register arms it again. Software can also force the flip-flop high or low without touching the flag. It can invert the pin polarity, select an open-drain style drive, and read back the flip-flop level, the flag and the armed state.

All register access uses a small write port and a combinational read port. Register map: select 0 is compare value A (leading edge), select 1 is compare value B (trailing edge), and select 2 is control/status.

Top module: `pulse_cmp_chan`

## Requirements
- R1: When `cnt_upd` is high and `cnt_bus` equals compare value A, the flip-flop is 1 after that clock edge. When it equals compare value B, the flip-flop is 0 after that edge.
- R2: A comparison is made only in a cycle with `cnt_upd` high. A matching `cnt_bus` value without the strobe changes neither the flip-flop nor the flag.
- R3: Control bit 1 (invert) set makes `pin_out` the inverse of the flip-flop level. When it is clear, `pin_out` equals the level (totem-pole drive).
- R4: Control/status bit 6 always reads the current flip-flop level.
- R5: In continuous mode (control bit 0 = 0), repeated A and B matches keep producing pulses while the flag stays set. In this mode the flag (status bit 5) is set by a match on either A or B.
- R6: A control write with bit 3 set forces the flip-flop to 1. A control write with bit 4 set forces it to 0, and bit 4 wins if both are set. A control write that carries a force bit leaves the flag unchanged, whatever its bit 5 value.
- R7: In one-shot mode (control bit 0 = 1), a B match disarms the comparators (status bit 7 goes to 0). Further A or B values then have no effect until compare register A or B is written, which arms them again.
- R8: In one-shot mode, only a B match sets the flag. An A match sets the flip-flop but not the flag.
- R9: If A and B hold the same value and it matches, the flip-flop is 0 after the edge and the flag is set.
- R10: With control bit 2 (open-drain) set, `pin_out` is 0 and `pin_oe` is high only while the pin level is low. With bit 2 clear, `pin_oe` is 1.
- R11: A control write without force bits and with bit 5 = 0 clears the flag. Writing bit 5 = 1 leaves it. A hardware flag set in the same cycle as such a clear wins.
- R12: After reset, the flip-flop, flag, armed state, control bits and compare values are all 0, so `pin_out` = 0 and `pin_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_bus | input | CNT_W | Shared counter value |
| cnt_upd | input | 1 | High in cycles where `cnt_bus` carries a new value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 = A, 1 = B, 2 = control |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read select, same encoding |
| rd_data | output | CNT_W | Combinational read data |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardware flag set and a software flag clear can land in the same cycle. The bench provokes this by issuing a control write with bit 5 low in the very cycle that an updated count equals B. The flag is then read back: it must still be 1, and a lone clear afterwards must drop it to 0. A second overlap is a forced edge arriving in a cycle where the flag is already set. The bench judges it by reading the flag right after the force.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   localparam int ADDR_W    = 2;
   localparam int CTRL_BITS = 8;

   typedef enum logic [ADDR_W-1:0] {
      SEL_DATA_A = 2'd0,
      SEL_DATA_B = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   localparam int CB_ONESHOT   = 0;
   localparam int CB_INVERT    = 1;
   localparam int CB_OPENDRAIN = 2;
   localparam int CB_FORCE_SET = 3;
   localparam int CB_FORCE_CLR = 4;
   localparam int CB_FLAG      = 5;
   localparam int CB_LEVEL     = 6;
   localparam int CB_ARMED     = 7;

   typedef struct packed {
      logic one_shot;
      logic invert;
      logic open_drain;
   } cfg_t;
endpackage

// File: rtl/pcc_match.sv
module pcc_match #(
   parameter int CNT_W = 16,
   parameter int NUM   = 2
) (
   input  logic [CNT_W-1:0]          cnt_bus,
   input  logic                      cnt_upd,
   input  logic                      cmp_en,
   input  logic [NUM-1:0][CNT_W-1:0] cmp_val,
   output logic [NUM-1:0]            hit
);
   if (NUM < 1) begin : g_bad_num
      $error("pcc_match: NUM must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_cmp
      assign hit[i] = cnt_upd && cmp_en && (cnt_bus == cmp_val[i]);
   end
endmodule

// File: rtl/pcc_regs.sv
module pcc_regs
   import pcc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [CNT_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic                hit_a,
   input  logic                hit_b,
   input  logic                ff_level,
   output logic [CNT_W-1:0]    data_a,
   output logic [CNT_W-1:0]    data_b,
   output cfg_t                cfg,
   output logic                frc_set,
   output logic                frc_clr,
   output logic                cmp_en,
   output logic                flag,
   output logic [CNT_W-1:0]    rd_data
);
   localparam int PAD_W = CNT_W - CTRL_BITS;

   if (PAD_W < 0) begin : g_bad_w
      $error("pcc_regs: CNT_W must hold the control byte");
   end

   reg_sel_e wsel, rsel;
   logic     wr_a, wr_b, wr_c, any_frc, flag_set, flag_clr, armed;

   assign wsel    = reg_sel_e'(wr_addr);
   assign rsel    = reg_sel_e'(rd_addr);
   assign wr_a    = wr_en && (wsel == SEL_DATA_A);
   assign wr_b    = wr_en && (wsel == SEL_DATA_B);
   assign wr_c    = wr_en && (wsel == SEL_CTRL);
   assign frc_set = wr_c && wr_data[CB_FORCE_SET];
   assign frc_clr = wr_c && wr_data[CB_FORCE_CLR];
   assign any_frc = frc_set || frc_clr;

   assign flag_set = hit_b || (hit_a && !cfg.one_shot);
   assign flag_clr = wr_c && !any_frc && !wr_data[CB_FLAG];
   assign cmp_en   = !cfg.one_shot || armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_a <= '0;
         data_b <= '0;
         cfg    <= '0;
         flag   <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (wr_a) data_a <= wr_data;
         if (wr_b) data_b <= wr_data;
         if (wr_c) begin
            cfg.one_shot   <= wr_data[CB_ONESHOT];
            cfg.invert     <= wr_data[CB_INVERT];
            cfg.open_drain <= wr_data[CB_OPENDRAIN];
         end
         if (flag_set)      flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         if (wr_a || wr_b)                  armed <= 1'b1;
         else if (hit_b && cfg.one_shot)    armed <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rsel)
         SEL_DATA_A: rd_data = data_a;
         SEL_DATA_B: rd_data = data_b;
         SEL_CTRL: begin
            rd_data[CB_ONESHOT]   = cfg.one_shot;
            rd_data[CB_INVERT]    = cfg.invert;
            rd_data[CB_OPENDRAIN] = cfg.open_drain;
            rd_data[CB_FLAG]      = flag;
            rd_data[CB_LEVEL]     = ff_level;
            rd_data[CB_ARMED]     = armed;
         end
         default: rd_data = '0;
      endcase
   end

   // R7
   disarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed) |-> $past(hit_b && cfg.one_shot));

   // R11
   flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set |=> flag);

   // R8
   oneshot_lead_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.one_shot && hit_a && !hit_b && !flag && !wr_c) |=> !flag);
endmodule

// File: rtl/pcc_outstage.sv
module pcc_outstage
   import pcc_pkg::*;
#(
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   input  logic frc_set,
   input  logic frc_clr,
   input  cfg_t cfg,
   output logic ff_q,
   output logic pin_out,
   output logic pin_oe
);
   logic level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ff_q <= 1'b0;
      else if (clr_ev || frc_clr)   ff_q <= 1'b0;
      else if (set_ev || frc_set)   ff_q <= 1'b1;
   end

   assign level = ff_q ^ cfg.invert;

   if (OD_SUPPORT) begin : g_od
      assign pin_out = cfg.open_drain ? 1'b0   : level;
      assign pin_oe  = cfg.open_drain ? !level : 1'b1;

      // R10
      od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg.open_drain |-> (!pin_out && (pin_oe == !level)));
   end else begin : g_pp
      logic unused_od;
      assign unused_od = cfg.open_drain;
      assign pin_out   = level;
      assign pin_oe    = 1'b1;
   end

   // R9
   equal_hit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && clr_ev) |=> !ff_q);

   // R1
   lead_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && !clr_ev && !frc_clr) |=> ff_q);
endmodule

// File: rtl/pulse_cmp_chan.sv
module pulse_cmp_chan
   import pcc_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_bus,
   input  logic             cnt_upd,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             pin_out,
   output logic             pin_oe
);
   localparam int NUM_CMP = 2;

   if (CNT_W < CTRL_BITS || CNT_W > 32) begin : g_bad_cnt_w
      $error("pulse_cmp_chan: CNT_W out of range");
   end

   logic [CNT_W-1:0]              data_a, data_b;
   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
   logic [NUM_CMP-1:0]            hit;
   cfg_t                          cfg;
   logic                          frc_set, frc_clr, cmp_en, flag, ff_q;

   assign cmp_val = {data_b, data_a};

   pcc_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr),
      .hit_a(hit[0]), .hit_b(hit[1]), .ff_level(ff_q),
      .data_a(data_a), .data_b(data_b), .cfg(cfg),
      .frc_set(frc_set), .frc_clr(frc_clr), .cmp_en(cmp_en),
      .flag(flag), .rd_data(rd_data)
   );

   pcc_match #(.CNT_W(CNT_W), .NUM(NUM_CMP)) u_match (
      .cnt_bus(cnt_bus), .cnt_upd(cnt_upd), .cmp_en(cmp_en),
      .cmp_val(cmp_val), .hit(hit)
   );

   pcc_outstage #(.OD_SUPPORT(OD_SUPPORT)) u_out (
      .clk(clk), .rst_n(rst_n),
      .set_ev(hit[0]), .clr_ev(hit[1]),
      .frc_set(frc_set), .frc_clr(frc_clr),
      .cfg(cfg), .ff_q(ff_q), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // R2
   no_strobe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_upd |-> (hit == '0));

   // R6
   force_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((frc_set || frc_clr) && (hit == '0)) |=> $stable(flag));
endmodule

// File: tb/sim_pulse_cmp_chan.sv
module sim_pulse_cmp_chan;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt_bus = '0;
   logic         cnt_upd = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         pin_out, pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pulse_cmp_chan #(.CNT_W(W), .OD_SUPPORT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_bus(cnt_bus), .cnt_upd(cnt_upd),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // control word: os bit0, inv bit1, od bit2, force set bit3, force clr bit4, flag bit5
   function automatic logic [W-1:0] cw(input bit os, input bit inv, input bit od,
                                       input bit fs, input bit fc, input bit keep);
      logic [W-1:0] v;
      v = '0;
      v[0] = os; v[1] = inv; v[2] = od; v[3] = fs; v[4] = fc; v[5] = keep;
      return v;
   endfunction

   task automatic step();
      @(posedge clk);
      #2;
      wr_en   = 1'b0;
      cnt_upd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
   endtask

   task automatic tick(input logic [W-1:0] c);
      cnt_bus = c; cnt_upd = 1'b1;
      step();
   endtask

   task automatic rd_ctl(output logic [W-1:0] v);
      rd_addr = 2'd2;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd_ctl(v);
      chk("R12 ctrl/status after reset", v, 0);
      chk("R12 pin_out after reset", pin_out, 0);
      chk("R12 pin_oe after reset", pin_oe, 1);
      rd_addr = 2'd0; #1;
      chk("R12 compare A after reset", rd_data, 0);
   endtask

   task automatic t_cont();
      logic [W-1:0] v;
      wr(2'd0, 16'd10);
      wr(2'd1, 16'd20);
      wr(2'd2, cw(0, 0, 0, 0, 0, 1));
      tick(16'd10);
      chk("R1 A match sets pin", pin_out, 1);
      rd_ctl(v);
      chk("R4 level bit after set", v[6], 1);
      chk("R5 flag on A match", v[5], 1);
      tick(16'd20);
      chk("R1 B match clears pin", pin_out, 0);
      rd_ctl(v);
      chk("R4 level bit after clear", v[6], 0);
      tick(16'd10);
      chk("R5 second pulse with flag still set", pin_out, 1);
      tick(16'd20);
      chk("R5 second pulse ends", pin_out, 0);
   endtask

   task automatic t_strobe();
      logic [W-1:0] v;
      wr(2'd2, cw(0, 0, 0, 0, 0, 0));
      cnt_bus = 16'd10;
      step(); step(); step();
      chk("R2 no compare without strobe (pin)", pin_out, 0);
      rd_ctl(v);
      chk("R2 no compare without strobe (flag)", v[5], 0);
   endtask

   task automatic t_pol();
      wr(2'd2, cw(0, 1, 0, 0, 0, 1));
      chk("R3 inverted idle pin", pin_out, 1);
      tick(16'd10);
      chk("R3 inverted active pin", pin_out, 0);
      tick(16'd20);
      wr(2'd2, cw(0, 0, 0, 0, 0, 0));
      chk("R3 direct idle pin", pin_out, 0);
   endtask

   task automatic t_force();
      logic [W-1:0] v;
      wr(2'd2, cw(0, 0, 0, 1, 0, 0));
      chk("R6 force set drives pin", pin_out, 1);
      rd_ctl(v);
      chk("R6 force set leaves flag clear", v[5], 0);
      tick(16'd20);
      wr(2'd2, cw(0, 0, 0, 1, 0, 0));
      rd_ctl(v);
      chk("R6 force set keeps flag set", v[5], 1);
      wr(2'd2, cw(0, 0, 0, 0, 1, 0));
      chk("R6 force clear drives pin low", pin_out, 0);
      rd_ctl(v);
      chk("R6 force clear keeps flag set", v[5], 1);
   endtask

   task automatic t_flag_race();
      logic [W-1:0] v;
      wr(2'd2, cw(0, 0, 0, 0, 0, 0));
      rd_ctl(v);
      chk("R11 software clear", v[5], 0);
      tick(16'd20);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = cw(0, 0, 0, 0, 0, 0);
      cnt_bus = 16'd20; cnt_upd = 1'b1;
      step();
      rd_ctl(v);
      chk("R11 hardware set beats clear", v[5], 1);
      wr(2'd2, cw(0, 0, 0, 0, 0, 1));
      rd_ctl(v);
      chk("R11 writing one keeps flag", v[5], 1);
      wr(2'd2, cw(0, 0, 0, 0, 0, 0));
      rd_ctl(v);
      chk("R11 lone clear afterwards", v[5], 0);
   endtask

   task automatic t_single();
      logic [W-1:0] v;
      wr(2'd2, cw(1, 0, 0, 0, 0, 0));
      wr(2'd0, 16'd30);
      wr(2'd1, 16'd40);
      rd_ctl(v);
      chk("R7 armed after data write", v[7], 1);
      tick(16'd30);
      chk("R7 one-shot leading edge", pin_out, 1);
      rd_ctl(v);
      chk("R8 no flag on A match", v[5], 0);
      tick(16'd40);
      chk("R7 one-shot trailing edge", pin_out, 0);
      rd_ctl(v);
      chk("R8 flag on B match", v[5], 1);
      chk("R7 disarmed after pulse", v[7], 0);
      wr(2'd2, cw(1, 0, 0, 0, 0, 0));
      tick(16'd30);
      chk("R7 disarmed ignores A", pin_out, 0);
      tick(16'd40);
      rd_ctl(v);
      chk("R7 disarmed ignores B", v[5], 0);
      wr(2'd1, 16'd40);
      rd_ctl(v);
      chk("R7 rearmed by B write", v[7], 1);
      tick(16'd30);
      chk("R7 rearmed pulse starts", pin_out, 1);
      tick(16'd40);
      chk("R7 rearmed pulse ends", pin_out, 0);
   endtask

   task automatic t_equal();
      logic [W-1:0] v;
      wr(2'd2, cw(0, 0, 0, 1, 0, 0));
      wr(2'd0, 16'd50);
      wr(2'd1, 16'd50);
      wr(2'd2, cw(0, 0, 0, 0, 0, 0));
      chk("R9 pin high before equal match", pin_out, 1);
      tick(16'd50);
      chk("R9 equal values give low", pin_out, 0);
      rd_ctl(v);
      chk("R9 equal values set flag", v[5], 1);
   endtask

   task automatic t_od();
      wr(2'd2, cw(0, 0, 1, 0, 0, 1));
      chk("R10 od low level pin_out", pin_out, 0);
      chk("R10 od low level drives", pin_oe, 1);
      wr(2'd2, cw(0, 0, 1, 1, 0, 1));
      chk("R10 od high level pin_out", pin_out, 0);
      chk("R10 od high level released", pin_oe, 0);
      wr(2'd2, cw(0, 0, 0, 0, 0, 1));
      chk("R10 totem pole enables", pin_oe, 1);
      chk("R10 totem pole drives high", pin_out, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #10;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_cont();
      t_strobe();
      t_pol();
      t_force();
      t_flag_race();
      t_single();
      t_equal();
      t_od();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule